// File: doc/BRIEF.md
# 32-Source Interrupt Controller

This block collects up to 32 interrupt requests and condenses them into two request lines for a processor: one normal and one critical. Each source can be set to sense either edges or levels, and to treat high/rising or low/falling as its active state. Every detected event is held in a status bit until software clears it. A per-source enable gates that status. The gated result is then steered by a per-source routing bit to one of the two outputs. Because the outputs are ordinary request lines, one instance can feed a single input of another instance to form a chained hierarchy.

Software reaches the block through a small word-addressed register port. A write takes effect on the clock edge where `bus_we` is high. Read data is registered: it shows the register selected by `bus_addr` one clock later. In every per-source register, source n occupies bit 31-n, so source 0 is the most significant bit. Raw request inputs are asynchronous. They pass through a synchronising flop chain before any edge or level decision is made.

Top module: `intc_core`

## Requirements
- R1: After a synchronous reset, the enable, routing, polarity and trigger registers and the status register read 0, and both request outputs are low.
- R2: Register word offsets are status 0, enable 2, routing (1 = critical) 3, polarity 4, trigger 5 and masked status 6. Offsets 7 and 8, and every other unlisted offset, read 0. Writes to offsets 6, 7 and 8 have no effect. Read data appears one clock after the address is presented.
- R3: Source n maps to bit 31-n of every per-source register. A request on source 0 therefore shows as 0x80000000 in status.
- R4: Trigger bit 1 selects edge sensing and 0 selects level sensing. Polarity bit 1 selects rising edge or active-high level; 0 selects falling edge or active-low level. An edge of the other direction does not set status.
- R5: An edge-sensed event sets its status bit, and the bit stays set after the input returns to its idle state. The input passes through two synchronising flops first.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves that bit unchanged.
- R7: A clear of a level-sensed source has no effect while its synchronised input is still active, whether or not the source is enabled.
- R8: Masked status reads as status AND enable.
- R9: Status bits latch whether or not the source is enabled. A source enabled later reports an event latched earlier.
- R10: The normal output is the registered OR of masked-status bits with routing 0. The critical output is the registered OR of masked-status bits with routing 1.
- R11: When a status clear and a new edge event for the same source fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_SRC | Raw request inputs, index n is source n |
| bus_addr | input | 4 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Registered read data |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench builds the controller with its defaults: 32 sources and a two-flop synchroniser. This puts both ends of the reversed bit mapping in reach, with source 0 at the top bit and source 31 at the bottom bit. It also fixes a known three-clock path from an input change to a status change, so the bench can place a clear write in exactly the cycle in which a new edge lands. A behavioural per-source model is compared against read data and both request outputs on every clock. Directed sequences cover edges in both directions, clears of level sources while their input is still active, late enabling, and routing to each output.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_ADDR_W = 4;
  typedef logic [REG_ADDR_W-1:0] reg_ofs_t;

  // Word offsets of the register port
  localparam reg_ofs_t OFS_STATUS = 4'd0;
  localparam reg_ofs_t OFS_ENABLE = 4'd2;
  localparam reg_ofs_t OFS_CRIT   = 4'd3;
  localparam reg_ofs_t OFS_POL    = 4'd4;
  localparam reg_ofs_t OFS_TRIG   = 4'd5;
  localparam reg_ofs_t OFS_MASKED = 4'd6;
  localparam reg_ofs_t OFS_VEC    = 4'd7;
  localparam reg_ofs_t OFS_VCFG   = 4'd8;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc_src_cell.sv
module intc_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic trig_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q;
  logic rise, fall, active, edge_hit, set_ev;

  always_comb begin
    rise     = sync_i & ~prev_q;
    fall     = ~sync_i & prev_q;
    active   = pol_i ? sync_i : ~sync_i;
    edge_hit = pol_i ? rise : fall;
    set_ev   = trig_i ? edge_hit : active;
  end

  // A new event takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (set_ev)     stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R7
  level_clr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !trig_i && (pol_i == sync_i)) |=> stat_q);

  // R11
  edge_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && trig_i && pol_i && sync_i && !prev_q) |=> stat_q);

  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_i) |=> stat_q);
endmodule

// File: rtl/intc_core.sv
module intc_core import intc_pkg::*; #(
  parameter int N_SRC       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      irq_i,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [N_SRC-1:0]      bus_wdata,
  output logic [N_SRC-1:0]      bus_rdata,
  output logic                  irq_norm_o,
  output logic                  irq_crit_o
);
  localparam int MSB = N_SRC - 1;

  logic [N_SRC-1:0] en_q, crit_q, pol_q, trig_q;
  logic [N_SRC-1:0] stat_v, clr_v, masked_v, irq_s;

  intc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (irq_i),
    .q_o (irq_s)
  );

  assign clr_v    = (bus_we && bus_addr == OFS_STATUS) ? bus_wdata : '0;
  assign masked_v = stat_v & en_q;

  // Source k lives at register bit MSB-k
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int B = MSB - k;
    intc_src_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .sync_i (irq_s[k]),
      .trig_i (trig_q[B]),
      .pol_i  (pol_q[B]),
      .clr_i  (clr_v[B]),
      .stat_o (stat_v[B])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_ENABLE: en_q   <= bus_wdata;
        OFS_CRIT:   crit_q <= bus_wdata;
        OFS_POL:    pol_q  <= bus_wdata;
        OFS_TRIG:   trig_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_STATUS:        bus_rdata <= stat_v;
        OFS_ENABLE:        bus_rdata <= en_q;
        OFS_CRIT:          bus_rdata <= crit_q;
        OFS_POL:           bus_rdata <= pol_q;
        OFS_TRIG:          bus_rdata <= trig_q;
        OFS_MASKED:        bus_rdata <= masked_v;
        OFS_VEC, OFS_VCFG: bus_rdata <= '0;
        default:           bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_norm_o <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_norm_o <= |(masked_v & ~crit_q);
      irq_crit_o <= |(masked_v & crit_q);
    end
  end

  // R8
  masked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_MASKED) |=> (bus_rdata == $past(stat_v & en_q)));

  // R2
  vec_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_VEC || bus_addr == OFS_VCFG) |=> (bus_rdata == '0));

  // R10
  crit_out_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat_v & en_q & crit_q)) |=> irq_crit_o);

  // R10
  norm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_v & en_q & ~crit_q)) |=> !irq_norm_o);
endmodule

// File: tb/intc_core_tb.sv
module intc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq = '1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_norm_o, irq_crit_o;

  int checks = 0;
  int fails  = 0;
  bit armed  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  intc_core u_dut (
    .clk(clk), .rst(rst), .irq_i(irq), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm_o(irq_norm_o), .irq_crit_o(irq_crit_o)
  );

  // Behavioural reference, source-indexed inputs, bit 31-n per register
  logic [31:0] m_s1, m_s2, m_prev, m_stat, m_en, m_crit, m_pol, m_trig, m_rd;
  logic        m_n, m_c;

  always @(posedge clk) begin
    logic [31:0] nst, rd;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_en = 0; m_crit = 0;
      m_pol = 0; m_trig = 0; m_rd = 0; m_n = 0; m_c = 0;
    end else begin
      case (int'(bus_addr))
        0: rd = m_stat;  2: rd = m_en;  3: rd = m_crit;
        4: rd = m_pol;   5: rd = m_trig; 6: rd = m_stat & m_en;
        default: rd = 0;
      endcase
      m_n = |(m_stat & m_en & ~m_crit);
      m_c = |(m_stat & m_en & m_crit);
      for (int n = 0; n < 32; n++) begin
        int b;
        bit s, p, hit, wipe;
        b = 31 - n; s = m_s2[n]; p = m_prev[n];
        if (m_trig[b]) hit = m_pol[b] ? (s && !p) : (!s && p);
        else           hit = m_pol[b] ? s : !s;
        wipe = bus_we && bus_addr == 0 && bus_wdata[b];
        nst[b] = hit ? 1'b1 : (wipe ? 1'b0 : m_stat[b]);
      end
      m_stat = nst; m_rd = rd;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
      if (bus_we) begin
        if (bus_addr == 2) m_en   = bus_wdata;
        if (bus_addr == 3) m_crit = bus_wdata;
        if (bus_addr == 4) m_pol  = bus_wdata;
        if (bus_addr == 5) m_trig = bus_wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R2 R8 rdata vs model", bus_rdata, m_rd);
      chk("R10 normal vs model", {31'b0, irq_norm_o}, {31'b0, m_n});
      chk("R10 critical vs model", {31'b0, irq_crit_o}, {31'b0, m_c});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a;
    @(negedge clk); chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_irq(input int k, input logic v);
    @(negedge clk); irq[k] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 rdata after reset", bus_rdata, 0);
    chk("R1 outputs after reset", {30'b0, irq_norm_o, irq_crit_o}, 0);
    armed = 1;
    wait_n(4);
    wr(0, '1);
    rd(0, 0, "R6 status cleared");
    rd(2, 0, "R1 enable"); rd(3, 0, "R1 routing");
    rd(4, 0, "R1 polarity"); rd(5, 0, "R1 trigger");

    // R2 register map
    wr(2, 32'h1234_5678); rd(2, 32'h1234_5678, "R2 enable rw");
    wr(3, 32'h0F0F_0F0F); rd(3, 32'h0F0F_0F0F, "R2 routing rw");
    wr(6, '1); rd(6, 0, "R2 masked read-only");
    wr(7, '1); rd(7, 0, "R2 vector zero");
    rd(8, 0, "R2 vector cfg zero"); rd(1, 0, "R2 hole zero"); rd(15, 0, "R2 hole zero");
    wr(2, 0); wr(3, 0);

    // active-high for all, inputs low
    wr(4, '1);
    @(negedge clk); irq = '0;
    wait_n(5); wr(0, '1);
    rd(0, 0, "R6 clear after config");
    wr(5, 32'hC000_0001);
    rd(0, 0, "R4 no edge no event");

    // R3 R5: rising edge on source 0
    set_irq(0, 1); wait_n(2); set_irq(0, 0); wait_n(5);
    rd(0, 32'h8000_0000, "R3 R5 source 0 edge latched");
    wr(0, 32'h8000_0000); rd(0, 0, "R6 write one clears");

    // R6 zeros leave bits
    set_irq(1, 1); wait_n(2); set_irq(1, 0); wait_n(5);
    rd(0, 32'h4000_0000, "R3 source 1 bit");
    wr(0, 32'hBFFF_FFFF); rd(0, 32'h4000_0000, "R6 zero leaves bit");
    wr(0, 32'h4000_0000); rd(0, 0, "R6 cleared");

    // R7 level clear ignored while active, source disabled
    set_irq(5, 1); wait_n(5);
    rd(0, 32'h0400_0000, "R4 level high sets");
    wr(0, 32'h0400_0000); rd(0, 32'h0400_0000, "R7 clear ignored while active");
    set_irq(5, 0); wait_n(5);
    rd(0, 32'h0400_0000, "R7 stays latched after release");
    wr(0, 32'h0400_0000); rd(0, 0, "R6 level clear when inactive");

    // R4 falling edge on source 31
    wr(4, 32'hFFFF_FFFE); wait_n(3);
    rd(0, 0, "R4 polarity change no event");
    set_irq(31, 1); wait_n(5);
    rd(0, 0, "R4 rising ignored when falling selected");
    set_irq(31, 0); wait_n(5);
    rd(0, 32'h0000_0001, "R4 R3 falling edge source 31");
    wr(0, 1); rd(0, 0, "R6 cleared");

    // R4 active-low level on source 7
    set_irq(7, 1);
    wr(4, 32'hFEFF_FFFE); wait_n(5);
    rd(0, 0, "R4 low level inactive");
    set_irq(7, 0); wait_n(5);
    rd(0, 32'h0100_0000, "R4 low level active");
    set_irq(7, 1); wait_n(4);
    wr(0, 32'h0100_0000); rd(0, 0, "R6 cleared");

    // R8 R9 R10
    wr(2, 32'h3000_0000); wr(3, 32'h1000_0000);
    set_irq(2, 1); wait_n(5);
    chk("R10 normal raised", {31'b0, irq_norm_o}, 1);
    chk("R10 critical quiet", {31'b0, irq_crit_o}, 0);
    rd(6, 32'h2000_0000, "R8 masked");
    set_irq(4, 1); wait_n(5);
    rd(0, 32'h2800_0000, "R9 disabled source latches");
    rd(6, 32'h2000_0000, "R8 disabled source masked");
    set_irq(4, 0); wait_n(4);
    wr(2, 32'h3800_0000);
    rd(6, 32'h2800_0000, "R9 late enable reports");
    set_irq(3, 1); wait_n(5);
    chk("R10 critical raised", {31'b0, irq_crit_o}, 1);
    @(negedge clk); irq[2] = 0; irq[3] = 0;
    wait_n(4); wr(0, '1); wait_n(3);
    chk("R10 outputs drop", {30'b0, irq_norm_o, irq_crit_o}, 0);

    // R11 clear meets new edge on source 1
    set_irq(1, 1); wait_n(2); set_irq(1, 0); wait_n(5);
    rd(0, 32'h4000_0000, "R5 source 1 set");
    @(negedge clk); irq[1] = 1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 32'h4000_0000;
    @(negedge clk); bus_we = 0;
    rd(0, 32'h4000_0000, "R11 event beats clear");
    wr(0, 32'h4000_0000); rd(0, 0, "R6 edge clear with input held");
    set_irq(1, 0); wait_n(4);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule